// File: doc/BRIEF.md
# Pixel Component Extractor

This block sits between a pixel fetch stream and the display output path. Each cycle it takes one raw pixel word and reduces it to an 8-bit red, green and blue triple. The word's size (one to four bytes) and byte order come from a format register. Each colour has its own select register giving the lowest bit of its field, the field width and a fallback value.

A field narrower than eight bits is widened by repeating its bit pattern downward. A field wider than eight bits keeps only its eight most significant bits. The fallback value replaces a colour in three cases: its width is programmed to zero, the pixel lies in the blanking region, or the upstream buffer has run dry.

The triple and a valid flag leave the block through one register stage.

Top module: `pix_component_extract`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), out_valid, out_r, out_g and out_b are all zero.
- R2: Outputs change only at a clock edge and reflect the inputs of the previous edge (one cycle of latency); out_valid equals pix_active from that edge.
- R3: For an active pixel with no underrun, a colour's field starts at the bit given by select bits 4:0 and is as wide as select bits 11:8; an 8-bit field is output unchanged.
- R4: A field of width 1 to 7 is placed in the top of the 8-bit output and its bits are repeated downward to fill the low bits (5-bit 10000 gives 0x84, 3-bit 001 gives 0x24, 1-bit 1 gives 0xFF).
- R5: A field of width 9 to 15 outputs its 8 most significant bits.
- R6: A colour whose width field is zero outputs its select bits 23:16.
- R7: When pix_active is low, all three colours output their select bits 23:16.
- R8: When pix_underrun is high, all three colours output their select bits 23:16, even for an active pixel.
- R9: Format bits 4:3 hold the pixel size in bytes minus one. Bytes of pix_data above that size read as zero for extraction.
- R10: Format bit 31 set reverses the order of the bytes within the pixel size before extraction; clear keeps byte 0 in pix_data bits 7:0.
- R11: With a 2-byte pixel and fields at offsets 11, 5 and 0 of widths 5, 6 and 5, a pixel of 0xF800 gives full red only and 0x07E0 gives full green only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_cfg | input | 32 | Format: bit 31 byte-reverse, bits 4:3 bytes minus one |
| red_sel | input | 32 | Red select: 23:16 fallback, 11:8 width, 4:0 lowest bit |
| grn_sel | input | 32 | Green select, same layout |
| blu_sel | input | 32 | Blue select, same layout |
| pix_data | input | 32 | Raw pixel word |
| pix_active | input | 1 | Pixel is valid and inside the visible area |
| pix_underrun | input | 1 | Upstream buffer underrun |
| out_valid | output | 1 | Registered copy of pix_active |
| out_r | output | 8 | Red component |
| out_g | output | 8 | Green component |
| out_b | output | 8 | Blue component |

## Verification
The block keeps only one register stage. A fault in the byte ordering, masking or expansion logic therefore appears on the colour outputs on the very next edge after the affected pixel, and then disappears once the pixel changes.

Each fault is only visible for patterns that reach it. The vectors use asymmetric byte values, every pixel size and both byte orders, so a misplaced byte shows as a wrong nibble. Fields of width 1, 3, 5, 6, 12 and 15 are used, so a wrong replication or truncation shows in the low bits.

Fallback selection is checked with distinct fallback values per colour, so a swapped channel is also visible.

// File: rtl/pce_pkg.sv
package pce_pkg;

    localparam int COMP_W   = 8;
    localparam int FIELD_W  = 16;
    localparam int LSB_W    = 5;
    localparam int WIDTH_W  = 4;
    localparam int NUM_CHAN = 3;

    typedef struct packed {
        logic [COMP_W-1:0]  dflt;
        logic [WIDTH_W-1:0] width;
        logic [LSB_W-1:0]   lsb;
    } chan_sel_t;

    typedef struct packed {
        logic       rev;
        logic [1:0] bytes_m1;
    } fmt_t;

    typedef struct packed {
        logic              valid;
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } pix_out_t;

    function automatic chan_sel_t decode_sel(input logic [31:0] raw);
        chan_sel_t s;
        s.dflt  = raw[23:16];
        s.width = raw[11:8];
        s.lsb   = raw[4:0];
        return s;
    endfunction

    function automatic fmt_t decode_fmt(input logic [31:0] raw);
        fmt_t f;
        f.rev      = raw[31];
        f.bytes_m1 = raw[4:3];
        return f;
    endfunction

endpackage

// File: rtl/pce_byte_norm.sv
module pce_byte_norm #(
    parameter int PIX_W = 32
) (
    input  logic [PIX_W-1:0] word_in,
    input  logic [1:0]       bytes_m1,
    input  logic             rev,
    output logic [PIX_W-1:0] word_out
);
    localparam int NBYTES = PIX_W / 8;

    always_comb begin
        word_out = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (i <= int'(bytes_m1)) begin
                if (rev)
                    word_out[i*8 +: 8] = word_in[(int'(bytes_m1) - i)*8 +: 8];
                else
                    word_out[i*8 +: 8] = word_in[i*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/pce_chan_expand.sv
module pce_chan_expand
    import pce_pkg::*;
#(
    parameter int PIX_W = 32
) (
    input  logic [PIX_W-1:0]  norm_word,
    input  chan_sel_t         sel,
    output logic [COMP_W-1:0] comp,
    output logic              zero_width
);
    localparam int SHW = 6;

    logic [PIX_W-1:0]   shifted;
    logic [FIELD_W-1:0] mask;
    logic [FIELD_W-1:0] field;
    logic [FIELD_W-1:0] top;
    logic [FIELD_W-1:0] rep1;
    logic [FIELD_W-1:0] rep2;
    logic [FIELD_W-1:0] rep4;
    logic [SHW-1:0]     w1;
    logic [SHW-1:0]     w2;
    logic [SHW-1:0]     w4;
    logic [SHW-1:0]     lshift;

    always_comb begin
        w1      = SHW'(sel.width);
        w2      = w1 << 1;
        w4      = w1 << 2;
        lshift  = SHW'(FIELD_W) - w1;
        shifted = norm_word >> sel.lsb;
        mask    = (FIELD_W'(1) << w1) - FIELD_W'(1);
        field   = shifted[FIELD_W-1:0] & mask;
        top     = field << lshift;
        rep1    = top  | (top  >> w1);
        rep2    = rep1 | (rep1 >> w2);
        rep4    = rep2 | (rep2 >> w4);
        comp    = rep4[FIELD_W-1 -: COMP_W];
        zero_width = (sel.width == '0);
    end
endmodule

// File: rtl/pix_component_extract.sv
module pix_component_extract
    import pce_pkg::*;
#(
    parameter int PIX_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       fmt_cfg,
    input  logic [31:0]       red_sel,
    input  logic [31:0]       grn_sel,
    input  logic [31:0]       blu_sel,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              pix_active,
    input  logic              pix_underrun,
    output logic              out_valid,
    output logic [7:0]        out_r,
    output logic [7:0]        out_g,
    output logic [7:0]        out_b
);
    fmt_t               fmt;
    chan_sel_t          sel_arr  [NUM_CHAN];
    logic [COMP_W-1:0]  comp_arr [NUM_CHAN];
    logic [NUM_CHAN-1:0] zw;
    logic [PIX_W-1:0]   norm;
    logic [COMP_W-1:0]  pick     [NUM_CHAN];
    pix_out_t           out_d, out_q;

    logic unused_cfg;
    assign unused_cfg = ^{fmt_cfg[30:5], fmt_cfg[2:0],
                          red_sel[31:24], red_sel[15:12], red_sel[7:5],
                          grn_sel[31:24], grn_sel[15:12], grn_sel[7:5],
                          blu_sel[31:24], blu_sel[15:12], blu_sel[7:5]};

    assign fmt        = decode_fmt(fmt_cfg);
    assign sel_arr[0] = decode_sel(red_sel);
    assign sel_arr[1] = decode_sel(grn_sel);
    assign sel_arr[2] = decode_sel(blu_sel);

    pce_byte_norm #(.PIX_W(PIX_W)) u_norm (
        .word_in  (pix_data),
        .bytes_m1 (fmt.bytes_m1),
        .rev      (fmt.rev),
        .word_out (norm)
    );

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        pce_chan_expand #(.PIX_W(PIX_W)) u_exp (
            .norm_word  (norm),
            .sel        (sel_arr[c]),
            .comp       (comp_arr[c]),
            .zero_width (zw[c])
        );
    end

    always_comb begin
        for (int c = 0; c < NUM_CHAN; c++) begin
            if (!pix_active || pix_underrun || zw[c])
                pick[c] = sel_arr[c].dflt;
            else
                pick[c] = comp_arr[c];
        end
        out_d.valid = pix_active;
        out_d.r     = pick[0];
        out_d.g     = pick[1];
        out_d.b     = pick[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign out_valid = out_q.valid;
    assign out_r     = out_q.r;
    assign out_g     = out_q.g;
    assign out_b     = out_q.b;
endmodule

// File: rtl/pix_extract_chk.sv
module pix_extract_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] red_sel,
    input logic [31:0] grn_sel,
    input logic [31:0] blu_sel,
    input logic        pix_active,
    input logic        pix_underrun,
    input logic        out_valid,
    input logic [7:0]  out_r,
    input logic [7:0]  out_g,
    input logic [7:0]  out_b
);
    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_active |=> out_valid);

    // R2
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_active |=> !out_valid);

    // R7
    blank_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_active |=> (out_r == $past(red_sel[23:16])) &&
                        (out_g == $past(grn_sel[23:16])) &&
                        (out_b == $past(blu_sel[23:16])));

    // R8
    underrun_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_underrun |=> (out_r == $past(red_sel[23:16])) &&
                         (out_g == $past(grn_sel[23:16])) &&
                         (out_b == $past(blu_sel[23:16])));

    // R6
    zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blu_sel[11:8] == 4'd0) |=> (out_b == $past(blu_sel[23:16])));
endmodule

bind pix_component_extract pix_extract_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .red_sel      (red_sel),
    .grn_sel      (grn_sel),
    .blu_sel      (blu_sel),
    .pix_active   (pix_active),
    .pix_underrun (pix_underrun),
    .out_valid    (out_valid),
    .out_r        (out_r),
    .out_g        (out_g),
    .out_b        (out_b)
);

// File: tb/tb_pix_component_extract.sv
module tb_pix_component_extract;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fmt_cfg = '0, red_sel = '0, grn_sel = '0, blu_sel = '0;
    logic [31:0] pix_data = '0;
    logic        pix_active = 1'b0, pix_underrun = 1'b0;
    logic        out_valid;
    logic [7:0]  out_r, out_g, out_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pix_component_extract dut (
        .clk(clk), .rst_n(rst_n), .fmt_cfg(fmt_cfg),
        .red_sel(red_sel), .grn_sel(grn_sel), .blu_sel(blu_sel),
        .pix_data(pix_data), .pix_active(pix_active), .pix_underrun(pix_underrun),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    // fmt, rsel, gsel, bsel, pixel, active, underrun, exp r, g, b
    localparam int NV = 12;
    localparam int VW = 32*5 + 2 + 24;
    localparam logic [VW-1:0] VEC [NV] = '{
        // R11 565 red
        {32'h8, 32'h50B, 32'h605, 32'h500, 32'h0000F800, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h00},
        // R11 565 green
        {32'h8, 32'h50B, 32'h605, 32'h500, 32'h000007E0, 1'b1, 1'b0, 8'h00, 8'hFF, 8'h00},
        // R4 5/6-bit replication
        {32'h8, 32'h50B, 32'h605, 32'h500, 32'h00008410, 1'b1, 1'b0, 8'h84, 8'h82, 8'h84},
        // R3 byte fields, 4 bytes
        {32'h18, 32'h810, 32'h808, 32'h800, 32'h00123456, 1'b1, 1'b0, 8'h12, 8'h34, 8'h56},
        // R5 wide fields, R6 zero width on blue
        {32'h18, 32'hC00, 32'hF04, 32'h005A0000, 32'h0000ABCD, 1'b1, 1'b0, 8'hBC, 8'h15, 8'h5A},
        // R9 one byte pixel, upper bytes zero
        {32'h0, 32'h800, 32'h808, 32'h804, 32'hFFFFFF3C, 1'b1, 1'b0, 8'h3C, 8'h00, 8'h03},
        // R10 reversed, 4 bytes
        {32'h80000018, 32'h810, 32'h808, 32'h800, 32'h11223344, 1'b1, 1'b0, 8'h33, 8'h22, 8'h11},
        // R10 reversed, 2 bytes
        {32'h80000008, 32'h808, 32'h800, 32'h810, 32'hAABB1234, 1'b1, 1'b0, 8'h34, 8'h12, 8'h00},
        // R10 reversed, 3 bytes
        {32'h80000010, 32'h810, 32'h808, 32'h800, 32'h99ABCDEF, 1'b1, 1'b0, 8'hEF, 8'hCD, 8'hAB},
        // R7 blanking
        {32'h8, 32'h0011050B, 32'h00220605, 32'h00330500, 32'h0000F800, 1'b0, 1'b0, 8'h11, 8'h22, 8'h33},
        // R8 underrun on active pixel
        {32'h8, 32'h0011050B, 32'h00220605, 32'h00330500, 32'h0000F800, 1'b1, 1'b1, 8'h11, 8'h22, 8'h33},
        // R4 widths 1 and 3
        {32'h18, 32'h100, 32'h101, 32'h300, 32'h00000001, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h24}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [VW-1:0] v);
        {fmt_cfg, red_sel, grn_sel, blu_sel, pix_data, pix_active, pix_underrun} = v[VW-1:24];
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset", {7'd0, out_valid, out_r, out_g, out_b}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            @(negedge clk);
            check($sformatf("R2/R3 vec%0d rgb", i), {8'h0, out_r, out_g, out_b},
                  {8'h0, VEC[i][23:0]});
            check($sformatf("R2 vec%0d valid", i), {31'd0, out_valid},
                  {31'd0, VEC[i][25]});
        end

        // R2 latency: output holds until the next edge
        @(negedge clk);
        apply(VEC[3]);
        #2;
        check("R2 hold before edge", {8'h0, out_r, out_g, out_b}, 32'h00FF0024);
        @(negedge clk);
        check("R2 update after edge", {8'h0, out_r, out_g, out_b}, 32'h00123456);

        // R6 zero width on red only, others extracted
        @(negedge clk);
        red_sel = 32'h00C30010;
        @(negedge clk);
        check("R6 zero width red", {8'h0, out_r, out_g, out_b}, 32'h00C33456);

        // R8 underrun while blanked also gives fallback
        @(negedge clk);
        red_sel = 32'h00440810; grn_sel = 32'h00550808; blu_sel = 32'h00660800;
        pix_active = 1'b0; pix_underrun = 1'b1;
        @(negedge clk);
        check("R8 underrun blank", {7'd0, out_valid, out_r, out_g, out_b}, 32'h00445566);

        // R1 asynchronous reset mid-run
        @(negedge clk);
        pix_active = 1'b1; pix_underrun = 1'b0;
        @(negedge clk);
        #1 rst_n = 1'b0;
        #1;
        check("R1 async reset", {7'd0, out_valid, out_r, out_g, out_b}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule